// File: doc/BRIEF.md
# Bounded Prediction Residual Mapper

This block sits between a pixel predictor and a Rice entropy coder. For each accepted pair of a pixel and its predicted value, it forms the signed prediction error, defined as pixel minus prediction. It also measures theta, the distance from the prediction to the nearer end of the unsigned pixel range. It then folds the error into an unsigned code.

Errors that lie within theta of zero are interleaved: non-negative errors take the even codes and negative errors take the odd codes. An error beyond theta can only lie on one side of zero, so it is placed linearly above the interleaved region. Because of this, the code never needs more bits than the pixel itself.

Samples marked as reference samples skip the mapping, and their raw pixel value is forwarded. The result leaves through one register stage, and the valid and reference flags are delayed to match it.

Top module: `resid_fold_mapper`

## Requirements
- R1: The error is taken as pixel minus prediction, so a pixel above the prediction counts as a positive error and a pixel below it counts as a negative error.
- R2: Theta is the smaller of the prediction and (2^PIX_W − 1 − prediction). This covers both the low end and the high end of the range.
- R3: An error e with 0 ≤ e ≤ theta produces code 2e. In particular, a pixel equal to its prediction gives code 0.
- R4: An error e with −theta ≤ e < 0 produces code 2|e| − 1.
- R5: Any other error produces code theta + |e|. Every code fits in PIX_W bits, and the maximum is 2^PIX_W − 1.
- R6: When in_ref is high with in_valid, out_code equals the raw pixel and out_ref is high. When in_ref is low, out_ref is low.
- R7: out_valid equals in_valid one clock earlier, and each code appears on the clock after its input is accepted.
- R8: While in_valid is low, out_code and out_ref keep their previous values.
- R9: While rst is high, out_valid, out_ref and out_code are all zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair is valid this cycle |
| in_ref | input | 1 | Marks a reference sample that is forwarded unmapped |
| in_pixel | input | PIX_W | Actual pixel value |
| in_pred | input | PIX_W | Predicted pixel value |
| out_valid | output | 1 | out_code holds a new result |
| out_ref | output | 1 | The result is a forwarded reference sample |
| out_code | output | PIX_W | Mapped residual, or the raw pixel for a reference sample |

## Verification
The datapath between input and output contains only one register stage. A wrong theta, a wrong sign decision or a wrong zone choice therefore shows up on out_code on the very next clock after the offending pair is accepted.

The vectors are placed so that each fault is exposed where it matters:
- Some sit exactly on the boundary e = ±theta, where a comparison that is off by one moves the code from the interleaved region to the linear region.
- Some use predictions near either end of the range, where choosing the wrong range limit changes theta.

A stuck or misaligned valid or hold path shows as a valid pulse in the wrong cycle, or as a code that changes while in_valid is low.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [1:0] {
    ZONE_POS = 2'd0,
    ZONE_NEG = 2'd1,
    ZONE_FAR = 2'd2
  } zone_e;
endpackage

// File: rtl/rfm_span.sv
// Error sign and magnitude, plus distance from prediction to nearer range limit.
module rfm_span #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pixel,
  input  logic [PIX_W-1:0] pred,
  output logic             neg,
  output logic [PIX_W-1:0] mag,
  output logic [PIX_W-1:0] theta
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [PIX_W:0]   diff;
  logic [PIX_W-1:0] top_gap;

  assign diff    = {1'b0, pixel} - {1'b0, pred};
  assign neg     = diff[PIX_W];
  assign mag     = neg ? (pred - pixel) : (pixel - pred);
  assign top_gap = PIX_MAX - pred;
  assign theta   = (pred < top_gap) ? pred : top_gap;
endmodule

// File: rtl/rfm_fold.sv
// Folds error magnitude and sign into an unsigned code bounded by the pixel range.
module rfm_fold
  import rfm_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             neg,
  input  logic [PIX_W-1:0] mag,
  input  logic [PIX_W-1:0] theta,
  output zone_e            zone,
  output logic [PIX_W-1:0] code
);
  localparam logic [PIX_W:0] ONE_W = {{PIX_W{1'b0}}, 1'b1};

  logic [PIX_W:0] wide;

  always_comb begin
    if (mag <= theta) zone = neg ? ZONE_NEG : ZONE_POS;
    else              zone = ZONE_FAR;
  end

  always_comb begin
    unique case (zone)
      ZONE_POS: wide = {mag, 1'b0};
      ZONE_NEG: wide = {mag, 1'b0} - ONE_W;
      default:  wide = {1'b0, theta} + {1'b0, mag};
    endcase
  end

  // R5: theta bound keeps every code within PIX_W bits
  always_comb begin
    assert_fits_range_R5: assert (wide[PIX_W] == 1'b0);
  end

  assign code = wide[PIX_W-1:0];
endmodule

// File: rtl/resid_fold_mapper.sv
module resid_fold_mapper
  import rfm_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_ref,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic [PIX_W-1:0] in_pred,
  output logic             out_valid,
  output logic             out_ref,
  output logic [PIX_W-1:0] out_code
);
  logic             err_neg;
  logic [PIX_W-1:0] err_mag;
  logic [PIX_W-1:0] theta;
  zone_e            zone;
  logic [PIX_W-1:0] fold_code;

  rfm_span #(.PIX_W(PIX_W)) u_span (
    .pixel (in_pixel),
    .pred  (in_pred),
    .neg   (err_neg),
    .mag   (err_mag),
    .theta (theta)
  );

  rfm_fold #(.PIX_W(PIX_W)) u_fold (
    .neg   (err_neg),
    .mag   (err_mag),
    .theta (theta),
    .zone  (zone),
    .code  (fold_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ref   <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ref  <= in_ref;
        out_code <= in_ref ? in_pixel : fold_code;
      end
    end
  end

  // R7: valid emerges exactly one clock after acceptance
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R6: reference samples leave unmapped and flagged
  assert_ref_raw_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && in_ref)) |-> (out_ref && out_code == $past(in_pixel)));

  // R3: an exact prediction yields code zero
  assert_exact_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && !in_ref && in_pixel == in_pred)) |-> (out_code == '0));

  // R8: idle cycles leave the result untouched
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_code) && $stable(out_ref)));
endmodule

// File: tb/sim_resid_fold_mapper.sv
`timescale 1ns/1ps
module sim_resid_fold_mapper;
  localparam int PIX_W = 8;
  localparam int NV = 17;

  // {ref, pixel, pred, expected code, requirement number}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'd100, 8'd100, 8'd0,   4'd3}, // R3 exact match
    {1'b0, 8'd105, 8'd100, 8'd10,  4'd1}, // R1 positive side even
    {1'b0, 8'd95,  8'd100, 8'd9,   4'd1}, // R1 negative side odd
    {1'b0, 8'd200, 8'd100, 8'd200, 4'd3}, // R3 e = +theta
    {1'b0, 8'd0,   8'd100, 8'd199, 4'd4}, // R4 e = -theta
    {1'b0, 8'd10,  8'd3,   8'd10,  4'd5}, // R5 beyond theta, low pred
    {1'b0, 8'd0,   8'd3,   8'd5,   4'd4}, // R4 boundary, low pred
    {1'b0, 8'd255, 8'd250, 8'd10,  4'd2}, // R2 theta from top limit
    {1'b0, 8'd200, 8'd250, 8'd55,  4'd5}, // R5 below, high pred
    {1'b0, 8'd0,   8'd250, 8'd255, 4'd5}, // R5 max code
    {1'b0, 8'd255, 8'd0,   8'd255, 4'd5}, // R5 theta zero
    {1'b0, 8'd0,   8'd0,   8'd0,   4'd3}, // R3 zero at bottom
    {1'b0, 8'd128, 8'd127, 8'd2,   4'd3}, // R3 mid range
    {1'b0, 8'd126, 8'd127, 8'd1,   4'd4}, // R4 mid range
    {1'b0, 8'd255, 8'd128, 8'd254, 4'd2}, // R2 theta 127 at pred 128
    {1'b0, 8'd0,   8'd128, 8'd255, 4'd2}, // R2 one past theta
    {1'b1, 8'd77,  8'd10,  8'd77,  4'd6}  // R6 reference forwarded
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ref = 1'b0;
  logic [PIX_W-1:0] in_pixel = '0;
  logic [PIX_W-1:0] in_pred = '0;
  logic             out_valid;
  logic             out_ref;
  logic [PIX_W-1:0] out_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  resid_fold_mapper #(.PIX_W(PIX_W)) u0 (
    .clk, .rst, .in_valid, .in_ref, .in_pixel, .in_pred,
    .out_valid, .out_ref, .out_code
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic r, input int pix, input int prd);
    in_valid = v; in_ref = r; in_pixel = pix[PIX_W-1:0]; in_pred = prd[PIX_W-1:0];
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", int'(out_valid), 0);
    check("R9 ref", int'(out_ref), 0);
    check("R9 code", int'(out_code), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][28], int'(VEC[i][27:20]), int'(VEC[i][19:12]));
      @(negedge clk);
      check($sformatf("R%0d code vec %0d", VEC[i][3:0], i), int'(out_code), int'(VEC[i][11:4]));
      check($sformatf("R7 valid vec %0d", i), int'(out_valid), 1);
      check($sformatf("R6 ref flag vec %0d", i), int'(out_ref), int'(VEC[i][28]));
    end

    // R8: idle cycles hold code and flag (last output was reference 77)
    drive(1'b0, 1'b0, 3, 200);
    @(negedge clk);
    check("R7 valid drops", int'(out_valid), 0);
    check("R8 code held", int'(out_code), 77);
    check("R8 ref held", int'(out_ref), 1);
    @(negedge clk);
    check("R8 code held 2", int'(out_code), 77);

    // R7 back-to-back stream, one clock latency each
    drive(1'b1, 1'b0, 50, 60);
    @(negedge clk);
    check("R7 stream first", int'(out_code), 19);
    check("R6 ref low", int'(out_ref), 0);
    drive(1'b1, 1'b0, 70, 60);
    @(negedge clk);
    check("R7 stream second", int'(out_code), 20);
    drive(1'b0, 1'b0, 0, 0);
    @(negedge clk);
    check("R7 stream end", int'(out_valid), 0);

    // R9 reset in mid run
    drive(1'b1, 1'b1, 99, 0);
    @(negedge clk);
    check("R6 ref before reset", int'(out_code), 99);
    rst = 1'b1;
    @(negedge clk);
    check("R9 valid after reset", int'(out_valid), 0);
    check("R9 code after reset", int'(out_code), 0);
    check("R9 ref after reset", int'(out_ref), 0);
    rst = 1'b0;
    drive(1'b0, 1'b0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule